// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of a UART with two byte slots. A byte written to the data port lands in a holding register. When the output stage is free, it moves into the frame register and goes out on the serial line. Software can therefore queue the next byte while the current one is still being sent. When a byte is waiting at the moment a frame finishes, the next frame follows it with no idle time on the line.

A single 8-bit control register holds the following fields:

- the transmit mode;
- the ninth bit to transmit;
- a stored ninth received bit;
- a stored receive flag;
- the transmit-done flag (TI).

The hardware sets TI in two cases. The first is when a frame ends. The second is when the data port is written while no frame is in progress; this tells software that the second slot is still free. Only a write to the control register clears TI.

Bit timing comes from an external 16x baud tick enable. The three framed modes use the serial line alone. The synchronous mode also drives a shift clock.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `txd` is 1, `shiftClk` is 1 and `ctlRdData` reads 0x00. A reset in mid-frame abandons the frame.
- R2: The control register fields are TI at bit 0, the stored receive flag at bit 1, the stored ninth received bit at bit 2, the ninth transmit bit at bit 3 and the mode at bits 5:4. Bits 7:6 read 0. Writing the receive flag or the ninth received bit has no effect on `txd`.
- R3: Mode 1 sends a 10-bit frame: a 0 start bit, 8 data bits LSB first, and a 1 stop bit. Each bit lasts 16 baud ticks.
- R4: Modes 2 and 3 send an 11-bit frame. The ninth bit sits between the eighth data bit and the stop bit. Each bit lasts 16 baud ticks.
- R5: Mode 0 sends the 8 data bits LSB first on `txd`, with no start bit and no stop bit. Each bit lasts 2 baud ticks. `shiftClk` is 0 during the first tick of each bit and 1 during the second. `txd` does not change on the rising edge of `shiftClk`.
- R6: TI becomes 1 on the clock edge that ends the last bit of a frame: the stop bit in modes 1, 2 and 3, or the eighth data bit in mode 0. TI is not set before that edge.
- R7: A data-port write while no frame is in progress sets TI one cycle after the write. A write during a frame leaves TI unchanged.
- R8: If a byte is waiting when a frame ends, its start bit begins on the same clock edge that ends the previous stop bit.
- R9: A write while a byte is already waiting replaces the waiting byte. The frame that follows carries the last byte written.
- R10: The ninth transmit bit is taken from the control register on the edge where its bit slot begins. A change made before that edge is sent. A change made during the slot does not alter `txd`.
- R11: Once TI is 1, it stays 1 until a control register write loads a 0 into bit 0. When the hardware sets TI and software writes the register in the same cycle, TI ends at 1.
- R12: Bit timing advances only on cycles where `baudTick` is 1. With one tick every second clock, each bit takes twice as many clocks.
- R13: `txd` is 1 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Enable pulse at 16 times the bit rate |
| bufWrEn | input | 1 | Write strobe for the data port |
| bufWrData | input | DATA_W | Byte to queue |
| ctlWrEn | input | 1 | Write strobe for the control register |
| ctlWrData | input | 8 | Control register write value |
| ctlRdData | output | 8 | Control register contents |
| txd | output | 1 | Serial data line |
| shiftClk | output | 1 | Shift clock, active in mode 0 only |

## Verification
A data-port write is registered on edge P0. TI shows its effect one cycle later, and a queued byte enters the frame register on edge P1. From P1 onward, bit k of a frame occupies the clocks from P1+T·k to P1+T·(k+1), where T is 16 ticks, or 2 ticks in mode 0. The final bit ends on edge P1+T·n, where n is the number of bits in the frame; that same edge sets TI and, when a byte is waiting, starts the next start bit. The bench counts rising edges from P1 and samples on falling edges at those offsets. It reads framed bits at mid-slot and reads mode-0 bits in both clock phases. It checks TI on the last falling edge before the end of a frame, expecting 0, and on the first falling edge after it, expecting 1.

// File: rtl/uart_txdb_pkg.sv
package uart_txdb_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC    = 2'd0,
    MODE_ASYNC8  = 2'd1,
    MODE_ASYNC9A = 2'd2,
    MODE_ASYNC9B = 2'd3
  } txMode_e;

  localparam int CTL_W        = 8;
  localparam int CTL_TI       = 0;
  localparam int CTL_RI       = 1;
  localparam int CTL_RXNINTH  = 2;
  localparam int CTL_TXNINTH  = 3;
  localparam int CTL_MODE_LO  = 4;
  localparam int CTL_MODE_HI  = 5;

  typedef struct packed {
    logic    loadFrame;
    logic    captureNinth;
    logic    active;
    txMode_e frameMode;
    logic    clkLowPhase;
    logic    ninthSrc;
  } dpCtl_t;

endpackage

// File: rtl/uart_txdb_ctrl.sv
module uart_txdb_ctrl
  import uart_txdb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int SYNC_TICKS = 2,
  localparam int POS_W     = $clog2(DATA_W + 3),
  localparam int TICK_W    = $clog2(OVERSAMPLE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             bufWrEn,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  output logic [CTL_W-1:0] ctlRdData,
  output dpCtl_t           dpCtl,
  output logic [POS_W-1:0] bitPos
);

  localparam logic [TICK_W-1:0] ASYNC_TICK_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0] SYNC_TICK_LAST  = TICK_W'(SYNC_TICKS - 1);
  localparam logic [POS_W-1:0]  SYNC_POS_LAST   = POS_W'(DATA_W - 1);
  localparam logic [POS_W-1:0]  A8_POS_LAST     = POS_W'(DATA_W + 1);
  localparam logic [POS_W-1:0]  A9_POS_LAST     = POS_W'(DATA_W + 2);
  localparam logic [POS_W-1:0]  LAST_DATA_POS   = POS_W'(DATA_W);

  // control register fields
  logic [1:0] modeQ;
  logic       tiQ, riQ, rxNinthQ, txNinthQ;

  // sequencer state
  logic              busyQ, holdFullQ;
  logic [TICK_W-1:0] tickQ;
  logic [POS_W-1:0]  posQ;
  txMode_e           frameModeQ;

  logic [TICK_W-1:0] tickLast;
  logic [POS_W-1:0]  posLast;
  logic lastTick, bitEnd, frameEnd, startFrame, tiSet, ninthMode;

  always_comb begin
    ninthMode = (frameModeQ == MODE_ASYNC9A) || (frameModeQ == MODE_ASYNC9B);
    tickLast  = (frameModeQ == MODE_SYNC) ? SYNC_TICK_LAST : ASYNC_TICK_LAST;
    unique case (frameModeQ)
      MODE_SYNC:   posLast = SYNC_POS_LAST;
      MODE_ASYNC8: posLast = A8_POS_LAST;
      default:     posLast = A9_POS_LAST;
    endcase
    lastTick   = baudTick && (tickQ == tickLast);
    bitEnd     = busyQ && lastTick;
    frameEnd   = bitEnd && (posQ == posLast);
    startFrame = holdFullQ && (!busyQ || frameEnd);
    tiSet      = frameEnd || (bufWrEn && !busyQ);
  end

  // control register: software load, hardware set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= 2'd0;
      txNinthQ <= 1'b0;
      rxNinthQ <= 1'b0;
      riQ      <= 1'b0;
      tiQ      <= 1'b0;
    end else if (ctlWrEn) begin
      modeQ    <= ctlWrData[CTL_MODE_HI:CTL_MODE_LO];
      txNinthQ <= ctlWrData[CTL_TXNINTH];
      rxNinthQ <= ctlWrData[CTL_RXNINTH];
      riQ      <= ctlWrData[CTL_RI];
      tiQ      <= ctlWrData[CTL_TI] | tiSet;
    end else if (tiSet) begin
      tiQ <= 1'b1;
    end
  end

  always_comb begin
    ctlRdData              = '0;
    ctlRdData[CTL_MODE_HI:CTL_MODE_LO] = modeQ;
    ctlRdData[CTL_TXNINTH] = txNinthQ;
    ctlRdData[CTL_RXNINTH] = rxNinthQ;
    ctlRdData[CTL_RI]      = riQ;
    ctlRdData[CTL_TI]      = tiQ;
  end

  // holding slot occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           holdFullQ <= 1'b0;
    else if (bufWrEn)    holdFullQ <= 1'b1;
    else if (startFrame) holdFullQ <= 1'b0;
  end

  // frame sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      tickQ      <= '0;
      posQ       <= '0;
      frameModeQ <= MODE_SYNC;
    end else if (startFrame) begin
      busyQ      <= 1'b1;
      tickQ      <= '0;
      posQ       <= '0;
      frameModeQ <= txMode_e'(modeQ);
    end else if (frameEnd) begin
      busyQ <= 1'b0;
      tickQ <= '0;
      posQ  <= '0;
    end else if (busyQ && baudTick) begin
      if (lastTick) begin
        tickQ <= '0;
        posQ  <= posQ + 1'b1;
      end else begin
        tickQ <= tickQ + 1'b1;
      end
    end
  end

  always_comb begin
    dpCtl.loadFrame    = startFrame;
    dpCtl.captureNinth = bitEnd && ninthMode && (posQ == LAST_DATA_POS);
    dpCtl.active       = busyQ;
    dpCtl.frameMode    = frameModeQ;
    dpCtl.clkLowPhase  = (tickQ == '0);
    dpCtl.ninthSrc     = txNinthQ;
    bitPos             = posQ;
  end

  // R11: flag is sticky without a register write
  p_ti_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (tiQ && !ctlWrEn) |=> tiQ);

  // R6: a finished frame always leaves the flag raised
  p_done_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> tiQ);

  // R8: a waiting byte starts on the edge that ends the frame
  p_no_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && holdFullQ) |=> (busyQ && posQ == '0 && tickQ == '0));

  // R12: no timing progress without a tick
  p_tick_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !baudTick) |=> ($stable(posQ) && $stable(tickQ)));

  // R7: a write during a frame cannot raise the flag by itself
  p_busy_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && bufWrEn && !frameEnd && !tiQ && !(ctlWrEn && ctlWrData[CTL_TI])) |=> !tiQ);

endmodule

// File: rtl/uart_txdb_dp.sv
module uart_txdb_dp
  import uart_txdb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int POS_W = $clog2(DATA_W + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  dpCtl_t            dpCtl,
  input  logic [POS_W-1:0]  bitPos,
  output logic              txd,
  output logic              shiftClk
);

  localparam logic [POS_W-1:0] NINTH_POS = POS_W'(DATA_W + 1);
  localparam logic [POS_W-1:0] DATA_LAST = POS_W'(DATA_W);

  logic [DATA_W-1:0] holdQ, frameQ;
  logic              ninthQ;
  logic [POS_W-1:0]  dataIdx;
  logic              dataBit, isSync, isNinthMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        holdQ <= '0;
    else if (bufWrEn) holdQ <= bufWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                frameQ <= '0;
    else if (dpCtl.loadFrame) frameQ <= holdQ;
  end

  // ninth bit is latched when its slot opens, not when the byte is queued
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   ninthQ <= 1'b0;
    else if (dpCtl.captureNinth) ninthQ <= dpCtl.ninthSrc;
  end

  always_comb begin
    isSync      = (dpCtl.frameMode == MODE_SYNC);
    isNinthMode = (dpCtl.frameMode == MODE_ASYNC9A) || (dpCtl.frameMode == MODE_ASYNC9B);
    dataIdx     = isSync ? bitPos : (bitPos - 1'b1);
    dataBit     = 1'b1;
    for (int i = 0; i < DATA_W; i++) begin
      if (dataIdx == POS_W'(i)) dataBit = frameQ[i];
    end
  end

  always_comb begin
    if (!dpCtl.active)                          txd = 1'b1;
    else if (isSync)                            txd = dataBit;
    else if (bitPos == '0)                      txd = 1'b0;
    else if (bitPos <= DATA_LAST)               txd = dataBit;
    else if (bitPos == NINTH_POS && isNinthMode) txd = ninthQ;
    else                                        txd = 1'b1;
  end

  always_comb shiftClk = !(dpCtl.active && isSync && dpCtl.clkLowPhase);

  // R13: line marks idle outside frames
  p_idle_mark_r13: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.active |-> (txd && shiftClk));

  // R10: ninth bit holds through its slot
  p_ninth_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.active && $past(dpCtl.active) && isNinthMode &&
     bitPos == NINTH_POS && $past(bitPos) == NINTH_POS) |-> $stable(txd));

  // R5: data is steady across the shift clock rising edge
  p_data_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.active && isSync && $rose(shiftClk) && $past(dpCtl.active)) |-> $stable(txd));

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_txdb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              ctlWrEn,
  input  logic [7:0]        ctlWrData,
  output logic [7:0]        ctlRdData,
  output logic              txd,
  output logic              shiftClk
);

  localparam int POS_W = $clog2(DATA_W + 3);

  dpCtl_t           dpCtl;
  logic [POS_W-1:0] bitPos;

  uart_txdb_ctrl #(
    .DATA_W    (DATA_W),
    .OVERSAMPLE(OVERSAMPLE),
    .SYNC_TICKS(SYNC_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .bufWrEn  (bufWrEn),
    .ctlWrEn  (ctlWrEn),
    .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData),
    .dpCtl    (dpCtl),
    .bitPos   (bitPos)
  );

  uart_txdb_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bufWrEn  (bufWrEn),
    .bufWrData(bufWrData),
    .dpCtl    (dpCtl),
    .bitPos   (bitPos),
    .txd      (txd),
    .shiftClk (shiftClk)
  );

endmodule

// File: tb/uart_tx_dbuf_tb.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b1;
  logic       bufWrEn = 1'b0;
  logic [7:0] bufWrData = '0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic [7:0] ctlRdData;
  logic       txd, shiftClk;

  int applied = 0;
  int errors  = 0;
  int cyc     = 0;
  int tickDiv = 1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_dbuf u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .txd(txd), .shiftClk(shiftClk)
  );

  // {mode[1:0], ninth, data[7:0]}
  localparam logic [10:0] VECS [8] = '{
    {2'd1, 1'b0, 8'h55}, {2'd1, 1'b0, 8'hA3}, {2'd2, 1'b1, 8'h0F}, {2'd2, 1'b0, 8'hF0},
    {2'd3, 1'b1, 8'h81}, {2'd0, 1'b0, 8'h96}, {2'd0, 1'b0, 8'h01}, {2'd1, 1'b0, 8'h00}
  };

  initial begin : tickGen
    int ph = 0;
    forever begin
      @(negedge clk);
      baudTick = (ph == 0);
      ph = (ph + 1 >= tickDiv) ? 0 : ph + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] ctlWord(input int m, input logic nb, input logic ti);
    return {2'b00, 2'(m), nb, 1'b0, 1'b0, ti};
  endfunction

  function automatic logic expBit(input int m, input logic [7:0] d, input logic nb, input int k);
    if (m == 0) return d[k];
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9) return (m == 1) ? 1'b1 : nb;
    return 1'b1;
  endfunction

  task automatic ctlWr(input logic [7:0] w);
    ctlWrEn = 1'b1; ctlWrData = w;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic bufWr(input logic [7:0] d);
    bufWrEn = 1'b1; bufWrData = d;
    @(negedge clk);
    bufWrEn = 1'b0;
  endtask

  task automatic waitCyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic runFrame(input int m, input logic nb, input logic [7:0] d);
    int per = (m == 0) ? 2 : 16;
    int len = (m == 0) ? 8 : ((m == 1) ? 10 : 11);
    ctlWr(ctlWord(m, nb, 1'b0));
    bufWr(d);
    check("R7 idle write sets TI", ctlRdData[0], 1);
    ctlWr(ctlWord(m, nb, 1'b0));
    for (int k = 0; k < len; k++) begin
      for (int j = 0; j < per; j++) begin
        if (m == 0) begin
          check("R5 sync data", txd, expBit(m, d, nb, k));
          check("R5 shift clock phase", shiftClk, (j != 0));
        end else if (j == per / 2) begin
          check((m == 1) ? "R3 frame bit" : "R4 frame bit", txd, expBit(m, d, nb, k));
        end
        if (k == len - 1 && j == per - 1) check("R6 TI not early", ctlRdData[0], 0);
        @(negedge clk);
      end
    end
    check("R6 TI at frame end", ctlRdData[0], 1);
    check("R13 idle line", txd, 1);
    check("R5 idle shift clock", shiftClk, 1);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin : main
    int s;
    repeat (3) @(negedge clk);
    check("R1 reset txd", txd, 1);
    check("R1 reset shiftClk", shiftClk, 1);
    check("R1 reset ctl", ctlRdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset ctl", ctlRdData, 8'h00);

    for (int v = 0; v < 8; v++)
      runFrame(int'(VECS[v][10:9]), VECS[v][8], VECS[v][7:0]);

    // R2: field layout, stored receive bits inert
    ctlWr(8'hD6);
    repeat (5) @(negedge clk);
    check("R2 readback", ctlRdData, 8'h16);
    check("R2 rx bits inert on txd", txd, 1);
    ctlWr(8'h00);

    // R8, R9: queued bytes, overwrite, gapless start
    ctlWr(ctlWord(1, 0, 0));
    bufWr(8'hC3);
    ctlWr(ctlWord(1, 0, 0));
    s = cyc;
    waitCyc(s + 30);
    bufWr(8'h11);
    check("R7 busy write leaves TI", ctlRdData[0], 0);
    bufWr(8'h5A);
    waitCyc(s + 159);
    check("R6 TI before end", ctlRdData[0], 0);
    waitCyc(s + 160);
    check("R6 TI on end", ctlRdData[0], 1);
    check("R8 start bit with no gap", txd, 0);
    for (int k = 1; k <= 8; k++) begin
      waitCyc(s + 160 + 16 * k + 8);
      check("R9 overwritten byte sent", txd, expBit(1, 8'h5A, 1'b0, k));
    end
    waitCyc(s + 330);
    check("R11 TI stays set", ctlRdData[0], 1);
    check("R13 idle after burst", txd, 1);
    ctlWr(ctlWord(1, 0, 0));
    check("R11 software clear", ctlRdData, 8'h10);

    // R10: ninth bit sampled at its slot
    ctlWr(ctlWord(2, 0, 0));
    bufWr(8'h3C);
    ctlWr(ctlWord(2, 0, 0));
    s = cyc;
    waitCyc(s + 50);
    ctlWr(ctlWord(2, 1, 0));
    waitCyc(s + 136);
    check("R4 last data bit", txd, 0);
    waitCyc(s + 150);
    check("R10 early change sent", txd, 1);
    ctlWr(ctlWord(2, 0, 0));
    waitCyc(s + 158);
    check("R10 late change ignored", txd, 1);
    waitCyc(s + 168);
    check("R4 stop bit", txd, 1);
    waitCyc(s + 176);
    check("R6 TI after 11 bits", ctlRdData[0], 1);
    waitCyc(s + 200);
    check("R11 TI held", ctlRdData[0], 1);
    ctlWr(ctlWord(1, 0, 0));

    // R12: half-rate ticks double the bit time
    tickDiv = 2;
    bufWr(8'h01);
    ctlWr(ctlWord(1, 0, 0));
    s = cyc;
    waitCyc(s + 20);
    check("R12 start bit still held", txd, 0);
    waitCyc(s + 48);
    check("R12 first data bit", txd, 1);
    waitCyc(s + 300);
    check("R12 TI not yet", ctlRdData[0], 0);
    waitCyc(s + 345);
    check("R12 TI after slow frame", ctlRdData[0], 1);
    tickDiv = 1;
    ctlWr(ctlWord(1, 0, 0));

    // R1: reset mid-frame
    bufWr(8'h00);
    ctlWr(ctlWord(1, 0, 0));
    repeat (40) @(negedge clk);
    check("R1 frame running", txd, 0);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-frame reset txd", txd, 1);
    check("R1 mid-frame reset ctl", ctlRdData, 8'h00);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check("R13 idle after reset", txd, 1);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule